// File: doc/BRIEF.md
# EDID Base Block Rewriter

This block sits in the byte stream of a 128-byte base display-identification block and emits a patched copy of it for a converter that bridges an analog sink and a digital sink. Input bytes come one per beat with a valid strobe. A start marker tags byte zero. Each accepted beat produces one output byte one clock later, so the block needs no storage for the data itself.

The mode input is sampled on the start beat and held for the rest of the block. It selects whether the rewritten block describes an analog input or a digital input. That choice sets the input-type bit and the extension count. The last byte is always regenerated so that the emitted block sums to zero.

While the bytes stream through, the block validates the fixed eight-byte header, the structure version and revision, and the incoming checksum. Each check raises a sticky flag. A start marker that arrives before a block is complete restarts the stream and sets an abort flag for the block that was cut short.

Top module: `edid_patch_stream`

## Requirements
- R1: Every accepted beat produces exactly one output byte with out_valid high on the clock after that beat. A beat is accepted when in_valid is high and either in_sob is high or a block is in progress. Beats with in_valid high outside a block produce no output.
- R2: hdr_err goes high when any of bytes 0 to 7 differs from 00 FF FF FF FF FF FF 00. Header bytes are passed to the output unchanged.
- R3: ver_err goes high when byte 0x12 is not 01h or byte 0x13 is not 03h.
- R4: Byte 0x14 is output with bit 7 forced to the mode and bits 6:0 unchanged. The mode is target_digital (1 = digital, 0 = analog), sampled on the start beat and held for the whole block.
- R5: Byte 0x7E is output as 01h in digital mode and 00h in analog mode.
- R6: Every byte other than 0x14, 0x7E and 0x7F is output unchanged.
- R7: Output byte 0x7F is the two's complement of the 8-bit sum of output bytes 0x00 to 0x7E, so all 128 output bytes sum to zero modulo 256.
- R8: csum_err goes high when the 128 input bytes do not sum to zero modulo 256. The output checksum is still corrected.
- R9: hdr_err, ver_err and csum_err stay high until the next start beat. A start beat clears each of them to that beat's own result.
- R10: out_last pulses high for one cycle together with the 128th output byte of a block.
- R11: A start beat while a block is in progress restarts the block at byte 0 and sets abort_flag. abort_flag holds until the next start beat, which clears it unless that beat also cuts a block short.
- R12: Idle cycles between beats inside a block do not change the output bytes or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_digital | input | 1 | Sink mode, 1 = digital, 0 = analog; sampled on the start beat |
| in_valid | input | 1 | Input byte strobe |
| in_sob | input | 1 | Marks the beat that carries byte 0 |
| in_byte | input | 8 | Input data byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Patched output byte |
| out_last | output | 1 | Done pulse on the final output byte |
| hdr_err | output | 1 | Sticky header mismatch flag |
| ver_err | output | 1 | Sticky version or revision mismatch flag |
| csum_err | output | 1 | Sticky incoming checksum flag |
| abort_flag | output | 1 | The previous block was cut short by a start beat |

## Verification
On the last beat, the block writes the regenerated checksum byte and evaluates the incoming checksum in the same cycle. Both depend on running sums that have been folded through every earlier beat. The bench therefore feeds blocks whose incoming sum is deliberately off, and blocks whose patched fields shift the output sum. It checks that csum_err reflects the raw input while byte 0x7F still zeroes the output sum.

A second collision is a start beat landing on an in-progress block. In that cycle the restart, the flag clear and the abort set all happen at once. The bench cuts a block partway through and judges the next block's bytes and flags against values computed from scratch.

// File: rtl/edid_patch_pkg.sv
package edid_patch_pkg;
   localparam int EDID_LEN   = 128;
   localparam int HDR_LEN    = 8;
   localparam int OFS_VER    = 'h12;
   localparam int OFS_REV    = 'h13;
   localparam int OFS_INPUT  = 'h14;
   localparam int OFS_EXT    = 'h7E;
   localparam int OFS_CSUM   = 'h7F;
   localparam int VER_VALUE  = 'h01;
   localparam int REV_VALUE  = 'h03;
   localparam int NFLAG      = 3;
   localparam int FLAG_HDR   = 0;
   localparam int FLAG_VER   = 1;
   localparam int FLAG_CSUM  = 2;

   typedef enum logic {
      SINK_ANALOG  = 1'b0,
      SINK_DIGITAL = 1'b1
   } sink_mode_e;

   function automatic logic [7:0] hdr_expected(input int pos);
      return (pos == 0 || pos == HDR_LEN - 1) ? 8'h00 : 8'hFF;
   endfunction
endpackage

// File: rtl/edid_beat_track.sv
module edid_beat_track #(
   parameter int LEN = 128,
   localparam int IW = $clog2(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sob,
   output logic          beat,
   output logic          first,
   output logic          last,
   output logic          cut,
   output logic [IW-1:0] beat_idx
);
   logic [IW-1:0] cnt_q;
   logic          active_q;

   always_comb begin
      first    = in_valid && in_sob;
      beat     = in_valid && (in_sob || active_q);
      beat_idx = in_sob ? '0 : cnt_q;
      last     = beat && (beat_idx == IW'(LEN - 1));
      cut      = first && active_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (beat) begin
         cnt_q    <= beat_idx + 1'b1;
         active_q <= !last;
      end
   end
endmodule

// File: rtl/edid_sum_track.sv
module edid_sum_track #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         beat,
   input  logic         first,
   input  logic [W-1:0] add_val,
   output logic [W-1:0] sum_before
);
   logic [W-1:0] acc_q;

   assign sum_before = first ? '0 : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (beat) acc_q <= sum_before + add_val;
   end
endmodule

// File: rtl/edid_sticky_flag.sv
module edid_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic beat,
   input  logic first,
   input  logic hit,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (beat) flag <= first ? hit : (flag | hit);
   end
endmodule

// File: rtl/edid_field_patch.sv
module edid_field_patch
   import edid_patch_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = 7
) (
   input  logic [W-1:0]  in_byte,
   input  logic [IW-1:0] idx,
   input  sink_mode_e    mode,
   output logic [W-1:0]  patched
);
   localparam logic [IW-1:0] IX_INPUT = IW'(OFS_INPUT);
   localparam logic [IW-1:0] IX_EXT   = IW'(OFS_EXT);

   always_comb begin
      patched = in_byte;
      if (idx == IX_INPUT)    patched = {mode == SINK_DIGITAL, in_byte[W-2:0]};
      else if (idx == IX_EXT) patched = W'(mode == SINK_DIGITAL);
   end
endmodule

// File: rtl/edid_patch_stream.sv
module edid_patch_stream
   import edid_patch_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BLOCK_LEN = EDID_LEN,
   localparam int IW       = $clog2(BLOCK_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              target_digital,
   input  logic              in_valid,
   input  logic              in_sob,
   input  logic [DATA_W-1:0] in_byte,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_last,
   output logic              hdr_err,
   output logic              ver_err,
   output logic              csum_err,
   output logic              abort_flag
);
   if (DATA_W != 8) begin : g_bad_width
      $error("edid_patch_stream: DATA_W must be 8");
   end
   if (BLOCK_LEN != EDID_LEN) begin : g_bad_len
      $error("edid_patch_stream: BLOCK_LEN must equal the base block length");
   end

   localparam logic [IW-1:0] IX_VER  = IW'(OFS_VER);
   localparam logic [IW-1:0] IX_REV  = IW'(OFS_REV);
   localparam logic [IW-1:0] IX_CSUM = IW'(OFS_CSUM);

   logic              beat, first, last, cut;
   logic [IW-1:0]     beat_idx;
   sink_mode_e        mode_q, mode_eff;
   logic [DATA_W-1:0] patched, next_byte;
   logic [DATA_W-1:0] in_sum, out_sum;
   logic [HDR_LEN-1:0] hdr_mis;
   logic [NFLAG-1:0]  flag_hit, flag_q;

   edid_beat_track #(.LEN(BLOCK_LEN)) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
      .beat(beat), .first(first), .last(last), .cut(cut), .beat_idx(beat_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= SINK_ANALOG;
      else if (first) mode_q <= sink_mode_e'(target_digital);
   end
   assign mode_eff = first ? sink_mode_e'(target_digital) : mode_q;

   edid_field_patch #(.W(DATA_W), .IW(IW)) u_patch (
      .in_byte(in_byte), .idx(beat_idx), .mode(mode_eff), .patched(patched)
   );

   edid_sum_track #(.W(DATA_W)) u_in_sum (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
      .add_val(in_byte), .sum_before(in_sum)
   );

   edid_sum_track #(.W(DATA_W)) u_out_sum (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
      .add_val(next_byte), .sum_before(out_sum)
   );

   assign next_byte = (beat_idx == IX_CSUM) ? DATA_W'(DATA_W'(0) - out_sum) : patched;

   for (genvar k = 0; k < HDR_LEN; k++) begin : g_hdr
      assign hdr_mis[k] = (beat_idx == IW'(k)) && (in_byte != hdr_expected(k));
   end

   always_comb begin
      flag_hit[FLAG_HDR]  = |hdr_mis;
      flag_hit[FLAG_VER]  = ((beat_idx == IX_VER) && (in_byte != DATA_W'(VER_VALUE))) ||
                            ((beat_idx == IX_REV) && (in_byte != DATA_W'(REV_VALUE)));
      flag_hit[FLAG_CSUM] = (beat_idx == IX_CSUM) && (DATA_W'(in_sum + in_byte) != '0);
   end

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      edid_sticky_flag u_flag (
         .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
         .hit(flag_hit[f]), .flag(flag_q[f])
      );
   end

   assign hdr_err  = flag_q[FLAG_HDR];
   assign ver_err  = flag_q[FLAG_VER];
   assign csum_err = flag_q[FLAG_CSUM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_byte   <= '0;
         out_last   <= 1'b0;
         abort_flag <= 1'b0;
      end else begin
         out_valid <= beat;
         out_last  <= last;
         if (beat)  out_byte   <= next_byte;
         if (first) abort_flag <= cut;
      end
   end
endmodule

// File: rtl/edid_patch_stream_chk.sv
module edid_patch_stream_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sob,
   input logic       out_valid,
   input logic [7:0] out_byte,
   input logic       out_last,
   input logic       hdr_err,
   input logic       ver_err,
   input logic       csum_err,
   input logic       abort_flag
);
   logic       start_d;
   logic [7:0] run_sum;
   logic [7:0] base_sum;

   assign base_sum = start_d ? 8'h00 : run_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_d <= 1'b0;
         run_sum <= 8'h00;
      end else begin
         start_d <= in_valid && in_sob;
         if (out_valid) run_sum <= base_sum + out_byte;
      end
   end

   AST_OUT_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R1
   AST_OUT_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (8'(base_sum + out_byte) == 8'h00)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_last); // R10
   AST_HDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_err && !(in_valid && in_sob)) |=> hdr_err); // R9
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sob) |=> (!ver_err && !csum_err)); // R9
   AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_flag) |-> $past(in_valid && in_sob)); // R11
endmodule

bind edid_patch_stream edid_patch_stream_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
   .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
   .hdr_err(hdr_err), .ver_err(ver_err), .csum_err(csum_err),
   .abort_flag(abort_flag)
);

// File: tb/edid_patch_stream_tb.sv
module edid_patch_stream_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       target_digital = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sob = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_last, hdr_err, ver_err, csum_err, abort_flag;
   logic [7:0] out_byte;

   int tests = 0;
   int fails = 0;
   int ocnt = 0;
   int done_cnt = 0;
   int cycles = 0;
   logic [7:0] blk [128];
   logic [7:0] obs [256];
   logic [7:0] expv [128];

   edid_patch_stream u_dut (
      .clk(clk), .rst_n(rst_n), .target_digital(target_digital),
      .in_valid(in_valid), .in_sob(in_sob), .in_byte(in_byte),
      .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
      .hdr_err(hdr_err), .ver_err(ver_err), .csum_err(csum_err),
      .abort_flag(abort_flag)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      cycles++;
      if (out_valid) begin
         if (ocnt < 256) obs[ocnt] = out_byte;
         ocnt++;
         if (out_last) done_cnt++;
      end
      if (cycles > WATCHDOG) begin
         tests++; fails++;
         $display("FAIL R1 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fix_sum();
      logic [7:0] s = 8'h00;
      for (int i = 0; i < 127; i++) s = 8'(s + blk[i]);
      blk[127] = 8'(8'h00 - s);
   endtask

   task automatic make_block(input int seed);
      for (int i = 0; i < 128; i++) blk[i] = 8'(i * 37 + seed * 11);
      for (int i = 0; i < 8; i++) blk[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
      blk[8'h12] = 8'h01;
      blk[8'h13] = 8'h03;
      blk[8'h14] = seed[0] ? 8'hA5 : 8'h25;
      blk[8'h7E] = 8'(seed * 3);
      fix_sum();
   endtask

   task automatic send_block(input bit dig, input int gap_every, input int stop_at,
                             input bit flip_mode);
      ocnt = 0; done_cnt = 0;
      for (int i = 0; i < 128; i++) begin
         if (i == stop_at) break;
         @(negedge clk);
         in_valid = 1'b1; in_sob = (i == 0); in_byte = blk[i];
         target_digital = (flip_mode && i > 0) ? !dig : dig;
         if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
            @(negedge clk);
            in_valid = 1'b0; in_sob = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sob = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_block(input bit dig);
      logic [7:0] s = 8'h00;
      int bad = 0, bad_i = 0;
      for (int i = 0; i < 127; i++) begin
         expv[i] = blk[i];
         if (i == 'h14) expv[i] = {dig, blk[i][6:0]};
         if (i == 'h7E) expv[i] = dig ? 8'h01 : 8'h00;
         s = 8'(s + expv[i]);
      end
      expv[127] = 8'(8'h00 - s);
      chk(ocnt == 128, "R1", "output beat count", ocnt, 128);
      chk(obs['h14] == expv['h14], "R4", "byte 0x14", obs['h14], expv['h14]);
      chk(obs['h7E] == expv['h7E], "R5", "byte 0x7E", obs['h7E], expv['h7E]);
      for (int i = 0; i < 127; i++)
         if (obs[i] != expv[i] && bad == 0) begin bad = 1; bad_i = i; end
      chk(bad == 0, "R6", "pass-through byte", obs[bad_i], expv[bad_i]);
      chk(obs[127] == expv[127], "R7", "checksum byte", obs[127], expv[127]);
      chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
   endtask

   task automatic check_flags();
      logic [7:0] s = 8'h00;
      bit eh = 0;
      bit ev;
      bit ec;
      for (int i = 0; i < 8; i++)
         if (blk[i] != ((i == 0 || i == 7) ? 8'h00 : 8'hFF)) eh = 1;
      ev = (blk['h12] != 8'h01) || (blk['h13] != 8'h03);
      for (int i = 0; i < 128; i++) s = 8'(s + blk[i]);
      ec = (s != 8'h00);
      chk(hdr_err == eh, "R2", "hdr_err", hdr_err, eh);
      chk(ver_err == ev, "R3", "ver_err", ver_err, ev);
      chk(csum_err == ec, "R8", "csum_err", csum_err, ec);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 0 && out_last == 0, "R1", "reset outputs", out_valid, 0);
      chk({hdr_err, ver_err, csum_err, abort_flag} == 0, "R9", "reset flags",
          {hdr_err, ver_err, csum_err, abort_flag}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: good blocks in both modes with varied gap patterns
      for (int seed = 1; seed <= 4; seed++)
         for (int dig = 0; dig < 2; dig++) begin
            make_block(seed);
            send_block(dig[0], seed - 1, -1, 1'b0);
            check_block(dig[0]);
            check_flags();
         end

      // R2: header sweep, one corrupted position at a time
      for (int k = 0; k < 8; k++) begin
         make_block(k + 5);
         blk[k] = blk[k] ^ 8'h10;
         fix_sum();
         send_block(k[0], 0, -1, 1'b0);
         check_block(k[0]);
         check_flags();
      end

      // R9: sticky hdr_err holds over idle cycles and idle beats
      repeat (3) @(negedge clk);
      chk(hdr_err == 1'b1, "R9", "hdr_err held while idle", hdr_err, 1);

      // R1: beats outside a block produce nothing
      ocnt = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sob = 1'b0; in_byte = 8'(i);
      end
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      chk(ocnt == 0, "R1", "outputs from stray beats", ocnt, 0);
      chk(hdr_err == 1'b1, "R9", "hdr_err after stray beats", hdr_err, 1);

      // R3: version and revision errors
      for (int v = 0; v < 2; v++) begin
         make_block(20 + v);
         blk['h12 + v] = 8'h02 + 8'(v * 2);
         fix_sum();
         send_block(1'b1, 3, -1, 1'b0);
         check_block(1'b1);
         check_flags();
      end

      // R8: bad incoming checksum, output still corrected
      for (int d = 1; d <= 2; d++) begin
         make_block(30 + d);
         blk[127] = 8'(blk[127] + d);
         send_block(d[0], 0, -1, 1'b0);
         check_block(d[0]);
         check_flags();
      end

      // R11: cut a block short, restart, then clean block clears abort
      make_block(40);
      send_block(1'b0, 0, 50, 1'b0);
      make_block(41);
      send_block(1'b1, 0, -1, 1'b0);
      chk(abort_flag == 1'b1, "R11", "abort after cut block", abort_flag, 1);
      check_block(1'b1);
      check_flags();
      make_block(42);
      send_block(1'b0, 2, -1, 1'b0);
      chk(abort_flag == 1'b0, "R11", "abort cleared by clean start", abort_flag, 0);
      check_block(1'b0);

      // R4: mode latched on the start beat even if target flips later
      for (int dig = 0; dig < 2; dig++) begin
         make_block(50 + dig);
         send_block(dig[0], 0, -1, 1'b1);
         check_block(dig[0]);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule